// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single channel of a legacy-style interval timer. A 16-bit down-counter advances on a one-cycle `tick` enable, which the surrounding logic derives from a fixed base clock of roughly 1.193 MHz. A `gate` input and an output pin `out_o` complete the channel. Software, or a byte-sequencing front end outside this block, issues a load strobe that carries a full reload value, a three-bit counting mode and a decimal-count select. The channel then runs one of six behaviours: a timeout, a gate-triggered one-shot, a rate generator, a square wave, a software strobe or a hardware strobe.

The current count, the pin level and a "count loaded" flag are presented as registered outputs. The flag drops when a non-reloading strobe or timeout mode expires. Counting runs either in plain binary or as four packed decimal digits. A reload value of zero stands for the largest count the number system can hold.

Top module: `pic_channel`

## Requirements
- R1: After a synchronous reset, `count_o` is 0, `out_o` is 1 and `loaded_o` is 0.
- R2: On a cycle with `load` high, the channel captures `load_val`, `mode_code` and `bcd_sel` at that clock edge. From the next cycle `count_o` shows the reload value, rounded down to even in square-wave mode. `loaded_o` is 1. `out_o` is 0 in mode 0 and 1 in every other mode. A load in the same cycle as a tick wins over the tick. Apart from a load, `count_o` changes only on a cycle with `tick` high.
- R3: Mode 0 (`mode_code`=0) is the timeout. `count_o` drops by one per tick while `gate` is 1 and holds while `gate` is 0. On the tick where the count becomes zero, `out_o` rises, `loaded_o` clears and counting stops.
- R4: Mode 1 is the triggered one-shot. After a load, the counter holds and `out_o` is 1. A rising edge of `gate` arms a trigger, and the first tick after it reloads the count and drives `out_o` low. Later ticks count down whatever the level of `gate`. When the count becomes zero, `out_o` returns high, counting stops and `loaded_o` stays 1.
- R5: Mode 2 is the rate generator. While `gate` is 1, each tick decrements the count. `out_o` goes low on the tick where the count becomes 1. On the next tick the count reloads and `out_o` returns high, so the period is N ticks.
- R6: In mode 2, a low `gate` halts the count, and `out_o` is forced to 1 on the next clock edge even if it was low.
- R7: Mode 3 is the square wave. With an even reload N, each tick while `gate` is 1 subtracts two. The count reloads and `out_o` toggles on the tick where it reaches zero, which gives N/2 ticks high and N/2 ticks low.
- R8: In mode 3 with an odd N, the high phase lasts (N+1)/2 ticks and the low phase (N-1)/2 ticks. The count shown is N-1 minus multiples of two, so it is never odd.
- R9: Mode 4 is the software strobe. The count is gated as in mode 0. On the tick where it becomes zero, `out_o` drops for one tick and then returns high. `loaded_o` clears and there is no reload.
- R10: Mode 5 is the hardware strobe. A rising `gate` starts the count as in mode 1, but `out_o` stays 1. On the tick where the count becomes zero, `out_o` pulses low for one tick and `loaded_o` clears. There is no reload.
- R11: The mode codes 6 and 7 act as modes 2 and 3.
- R12: With `bcd_sel`=1, the count is four packed decimal digits, the lowest digit in bits 3:0. A digit that decrements past 0 wraps to 9 and borrows from the digit above it. Reload values are assumed to be valid decimal.
- R13: A reload of zero acts as 65536 counts in binary and 10000 in decimal. The first tick wraps the count to 0xFFFF or 0x9999, or to 0xFFFE or 0x9998 in mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one cycle per base-clock period |
| gate | input | 1 | Gate level |
| load | input | 1 | Load strobe |
| load_val | input | 16 | Reload value (binary or packed decimal) |
| mode_code | input | 3 | Counting mode |
| bcd_sel | input | 1 | 1 = decimal counting |
| count_o | output | 16 | Current count |
| out_o | output | 1 | Output pin level |
| loaded_o | output | 1 | Count-loaded flag |

## Verification
The bench builds the channel with its default of four digits, so the counter is 16 bits wide. At that width a zero reload is a 65536-tick run in binary and a 10000-tick run in decimal, and both are short enough to be driven to their end and checked exactly. The same width also makes it possible to see the 0x9999 and 0x9998 wraps and the borrow across every digit. Small odd and even reloads bring the square-wave phase split and the extra high tick into view within a few ticks.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [2:0] {
    MD_TIMEOUT   = 3'd0,
    MD_TRIG_ONE  = 3'd1,
    MD_RATE      = 3'd2,
    MD_SQUARE    = 3'd3,
    MD_SW_STROBE = 3'd4,
    MD_HW_STROBE = 3'd5
  } mode_e;

  // R11: the two spare codes fold onto the periodic modes
  function automatic mode_e fold_mode(input logic [2:0] code);
    case (code)
      3'd6:    fold_mode = MD_RATE;
      3'd7:    fold_mode = MD_SQUARE;
      default: fold_mode = mode_e'(code);
    endcase
  endfunction

endpackage

// File: rtl/pic_decr.sv
// Decrement by one or two, binary or packed decimal (R12, R13)
module pic_decr #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val,
  input  logic                bcd,
  input  logic                by_two,
  output logic [4*DIGITS-1:0] nxt,
  output logic                is_zero
);
  localparam int W = 4 * DIGITS;

  logic [W-1:0]      bin_nxt;
  logic [W-1:0]      bcd_nxt;
  logic [DIGITS-1:0] brw;

  assign bin_nxt = val - (by_two ? W'(2) : W'(1));
  assign brw[0]  = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] d;
    logic [2:0] sub;
    logic [4:0] diff;
    assign d = val[4*g +: 4];
    if (g == 0) begin : g_lo
      assign sub = by_two ? 3'd2 : 3'd1;
    end else begin : g_hi
      assign sub = {2'b00, brw[g]};
    end
    assign diff = {1'b0, d} - {2'b00, sub};
    assign bcd_nxt[4*g +: 4] = diff[4] ? (diff[3:0] + 4'd10) : diff[3:0];
    if (g < DIGITS - 1) begin : g_chain
      assign brw[g+1] = diff[4];
    end
  end

  assign nxt     = bcd ? bcd_nxt : bin_nxt;
  assign is_zero = (nxt == '0);

endmodule

// File: rtl/pic_gate_edge.sv
// Captures a rising gate edge as a pending trigger (R4, R10)
module pic_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic clear,
  input  logic consume,
  output logic pend
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      gate_q <= gate;
      if (clear)                pend <= 1'b0;
      else if (gate && !gate_q) pend <= 1'b1;
      else if (consume)         pend <= 1'b0;
    end
  end

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                gate,
  input  logic                load,
  input  logic [4*DIGITS-1:0] load_val,
  input  logic [2:0]          mode_code,
  input  logic                bcd_sel,
  input  logic                pend,
  input  logic [4*DIGITS-1:0] dec_nxt,
  input  logic                dec_zero,
  output logic [4*DIGITS-1:0] count_q,
  output logic                out_q,
  output logic                loaded_q,
  output logic                consume,
  output logic                dec_by_two,
  output logic                dec_bcd
);
  localparam int W = 4 * DIGITS;

  mode_e       mode_q;
  mode_e       load_mode;
  logic        bcd_q;
  logic        run_q;
  logic        extra_q;
  logic [W-1:0] reload_q;
  logic [W-1:0] reload_even;

  assign load_mode   = fold_mode(mode_code);
  assign reload_even = {reload_q[W-1:1], 1'b0};
  assign dec_by_two  = (mode_q == MD_SQUARE);
  assign dec_bcd     = bcd_q;
  assign consume     = tick && pend &&
                       ((mode_q == MD_TRIG_ONE) || (mode_q == MD_HW_STROBE));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_TIMEOUT;
      bcd_q    <= 1'b0;
      reload_q <= '0;
      count_q  <= '0;
      out_q    <= 1'b1;
      loaded_q <= 1'b0;
      run_q    <= 1'b0;
      extra_q  <= 1'b0;
    end else if (load) begin
      // R2: load wins over any tick in the same cycle
      mode_q   <= load_mode;
      bcd_q    <= bcd_sel;
      reload_q <= load_val;
      count_q  <= (load_mode == MD_SQUARE) ? {load_val[W-1:1], 1'b0} : load_val;
      out_q    <= (load_mode != MD_TIMEOUT);
      loaded_q <= 1'b1;
      extra_q  <= 1'b0;
      run_q    <= (load_mode == MD_TIMEOUT) || (load_mode == MD_SW_STROBE);
    end else begin
      case (mode_q)
        MD_TIMEOUT: begin  // R3
          if (tick && gate && run_q) begin
            count_q <= dec_nxt;
            if (dec_zero) begin
              out_q    <= 1'b1;
              loaded_q <= 1'b0;
              run_q    <= 1'b0;
            end
          end
        end
        MD_SW_STROBE: begin  // R9
          if (tick) begin
            if (!out_q) out_q <= 1'b1;
            if (gate && run_q) begin
              count_q <= dec_nxt;
              if (dec_zero) begin
                out_q    <= 1'b0;
                loaded_q <= 1'b0;
                run_q    <= 1'b0;
              end
            end
          end
        end
        MD_TRIG_ONE: begin  // R4
          if (tick) begin
            if (pend) begin
              count_q <= reload_q;
              out_q   <= 1'b0;
              run_q   <= 1'b1;
            end else if (run_q) begin
              count_q <= dec_nxt;
              if (dec_zero) begin
                out_q <= 1'b1;
                run_q <= 1'b0;
              end
            end
          end
        end
        MD_HW_STROBE: begin  // R10
          if (tick) begin
            if (!out_q) out_q <= 1'b1;
            if (pend) begin
              count_q <= reload_q;
              run_q   <= 1'b1;
            end else if (run_q) begin
              count_q <= dec_nxt;
              if (dec_zero) begin
                out_q    <= 1'b0;
                loaded_q <= 1'b0;
                run_q    <= 1'b0;
              end
            end
          end
        end
        MD_RATE: begin  // R5, R6
          if (!gate) begin
            out_q <= 1'b1;
          end else if (tick) begin
            if (count_q == W'(1)) begin
              count_q <= reload_q;
              out_q   <= 1'b1;
            end else begin
              count_q <= dec_nxt;
              if (dec_nxt == W'(1)) out_q <= 1'b0;
            end
          end
        end
        MD_SQUARE: begin  // R7, R8
          if (tick && gate) begin
            if (extra_q) begin
              out_q   <= 1'b0;
              count_q <= reload_even;
              extra_q <= 1'b0;
            end else begin
              count_q <= dec_nxt;
              if (dec_zero) begin
                if (out_q && reload_q[0]) begin
                  extra_q <= 1'b1;
                end else begin
                  out_q   <= ~out_q;
                  count_q <= reload_even;
                end
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pic_channel.sv
module pic_channel #(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                gate,
  input  logic                load,
  input  logic [4*DIGITS-1:0] load_val,
  input  logic [2:0]          mode_code,
  input  logic                bcd_sel,
  output logic [4*DIGITS-1:0] count_o,
  output logic                out_o,
  output logic                loaded_o
);
  localparam int W = 4 * DIGITS;

  logic         pend;
  logic         consume;
  logic         by_two;
  logic         bcd_run;
  logic         dec_zero;
  logic [W-1:0] dec_nxt;

  pic_gate_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .gate    (gate),
    .clear   (load),
    .consume (consume),
    .pend    (pend)
  );

  pic_decr #(.DIGITS(DIGITS)) u_decr (
    .val     (count_o),
    .bcd     (bcd_run),
    .by_two  (by_two),
    .nxt     (dec_nxt),
    .is_zero (dec_zero)
  );

  pic_ctrl #(.DIGITS(DIGITS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .gate       (gate),
    .load       (load),
    .load_val   (load_val),
    .mode_code  (mode_code),
    .bcd_sel    (bcd_sel),
    .pend       (pend),
    .dec_nxt    (dec_nxt),
    .dec_zero   (dec_zero),
    .count_q    (count_o),
    .out_q      (out_o),
    .loaded_q   (loaded_o),
    .consume    (consume),
    .dec_by_two (by_two),
    .dec_bcd    (bcd_run)
  );

endmodule

// File: rtl/pic_channel_chk.sv
module pic_channel_chk
  import pic_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                gate,
  input logic                load,
  input logic [4*DIGITS-1:0] load_val,
  input logic [2:0]          mode_code,
  input logic                bcd_sel,
  input logic [4*DIGITS-1:0] count_o,
  input logic                out_o,
  input logic                loaded_o
);
  logic  sq_q, rate_q, shot_q, bcd_q;
  mode_e lm;

  assign lm = fold_mode(mode_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_q <= 1'b0; rate_q <= 1'b0; shot_q <= 1'b0; bcd_q <= 1'b0;
    end else if (load) begin
      sq_q   <= (lm == MD_SQUARE);
      rate_q <= (lm == MD_RATE);
      shot_q <= (lm == MD_TIMEOUT) || (lm == MD_SW_STROBE) || (lm == MD_HW_STROBE);
      bcd_q  <= bcd_sel;
    end
  end

  function automatic logic digits_ok(input logic [4*DIGITS-1:0] v);
    for (int i = 0; i < DIGITS; i++)
      if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  p_load_flag_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> loaded_o);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(count_o));

  p_flag_drop_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(loaded_o) |-> shot_q);

  p_gate_release_r6: assert property (@(posedge clk) disable iff (rst)
    (rate_q && !gate && !load) |=> out_o);

  p_even_count_r8: assert property (@(posedge clk) disable iff (rst)
    sq_q |-> !count_o[0]);

  p_digits_r12: assert property (@(posedge clk) disable iff (rst)
    (bcd_q && digits_ok(load_val)) |-> digits_ok(count_o));

endmodule

bind pic_channel pic_channel_chk #(.DIGITS(DIGITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .gate      (gate),
  .load      (load),
  .load_val  (load_val),
  .mode_code (mode_code),
  .bcd_sel   (bcd_sel),
  .count_o   (count_o),
  .out_o     (out_o),
  .loaded_o  (loaded_o)
);

// File: tb/pic_channel_test.sv
`timescale 1ns/1ps
module pic_channel_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        gate = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode_code = '0;
  logic        bcd_sel = 1'b0;
  logic [15:0] count_o;
  logic        out_o;
  logic        loaded_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pic_channel uut (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .load(load),
    .load_val(load_val), .mode_code(mode_code), .bcd_sel(bcd_sel),
    .count_o(count_o), .out_o(out_o), .loaded_o(loaded_o)
  );

  typedef struct packed {
    logic [2:0]  md;
    logic        bcd;
    logic [15:0] rl;
    logic [16:0] nt;
    logic [15:0] ecnt;
    logic        eout;
    logic        eld;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 1'b0, 16'd10,     17'd3,     16'd7,      1'b0, 1'b1}, // R3
    '{3'd0, 1'b0, 16'd10,     17'd10,    16'd0,      1'b1, 1'b0}, // R3
    '{3'd0, 1'b0, 16'd10,     17'd12,    16'd0,      1'b1, 1'b0}, // R3 stop
    '{3'd0, 1'b1, 16'h0100,   17'd1,     16'h0099,   1'b0, 1'b1}, // R12
    '{3'd0, 1'b1, 16'h0010,   17'd10,    16'h0000,   1'b1, 1'b0}, // R12
    '{3'd4, 1'b0, 16'd4,      17'd4,     16'd0,      1'b0, 1'b0}, // R9
    '{3'd4, 1'b0, 16'd4,      17'd5,     16'd0,      1'b1, 1'b0}, // R9
    '{3'd2, 1'b0, 16'd5,      17'd4,     16'd1,      1'b0, 1'b1}, // R5
    '{3'd2, 1'b0, 16'd5,      17'd5,     16'd5,      1'b1, 1'b1}, // R5
    '{3'd2, 1'b0, 16'd5,      17'd6,     16'd4,      1'b1, 1'b1}, // R5
    '{3'd3, 1'b0, 16'd6,      17'd2,     16'd2,      1'b1, 1'b1}, // R7
    '{3'd3, 1'b0, 16'd6,      17'd3,     16'd6,      1'b0, 1'b1}, // R7
    '{3'd3, 1'b0, 16'd6,      17'd6,     16'd6,      1'b1, 1'b1}, // R7
    '{3'd3, 1'b0, 16'd7,      17'd3,     16'd0,      1'b1, 1'b1}, // R8
    '{3'd3, 1'b0, 16'd7,      17'd4,     16'd6,      1'b0, 1'b1}, // R8
    '{3'd3, 1'b0, 16'd7,      17'd7,     16'd6,      1'b1, 1'b1}, // R8
    '{3'd6, 1'b0, 16'd5,      17'd4,     16'd1,      1'b0, 1'b1}, // R11
    '{3'd7, 1'b0, 16'd7,      17'd4,     16'd6,      1'b0, 1'b1}, // R11
    '{3'd3, 1'b1, 16'h0011,   17'd1,     16'h0008,   1'b1, 1'b1}, // R12
    '{3'd0, 1'b0, 16'd0,      17'd1,     16'hFFFF,   1'b0, 1'b1}, // R13
    '{3'd0, 1'b0, 16'd0,      17'd65536, 16'd0,      1'b1, 1'b0}, // R13
    '{3'd0, 1'b1, 16'd0,      17'd1,     16'h9999,   1'b0, 1'b1}, // R13
    '{3'd0, 1'b1, 16'd0,      17'd10000, 16'd0,      1'b1, 1'b0}, // R13
    '{3'd3, 1'b1, 16'd0,      17'd1,     16'h9998,   1'b1, 1'b1}, // R13
    '{3'd0, 1'b0, 16'd10,     17'd0,     16'd10,     1'b0, 1'b1}  // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] md, input logic bcd, input logic [15:0] v);
    @(negedge clk);
    load = 1'b1; mode_code = md; bcd_sel = bcd; load_val = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic pulse_gate();
    @(negedge clk); gate = 1'b1;
    @(negedge clk); gate = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 count", 32'(count_o), 32'd0);
    check("R1 out", 32'(out_o), 32'd1);
    check("R1 loaded", 32'(loaded_o), 32'd0);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      gate = 1'b1;
      do_load(TBL[i].md, TBL[i].bcd, TBL[i].rl);
      run_ticks(int'(TBL[i].nt));
      check($sformatf("vec%0d count", i), 32'(count_o), 32'(TBL[i].ecnt));
      check($sformatf("vec%0d out", i), 32'(out_o), 32'(TBL[i].eout));
      check($sformatf("vec%0d loaded", i), 32'(loaded_o), 32'(TBL[i].eld));
    end

    // R2: load wins over a simultaneous tick
    @(negedge clk);
    tick = 1'b1; load = 1'b1; mode_code = 3'd0; bcd_sel = 1'b0; load_val = 16'd20;
    @(negedge clk);
    tick = 1'b0; load = 1'b0;
    check("R2 load priority", 32'(count_o), 32'd20);

    // R3: low gate halts mode 0
    gate = 1'b0;
    do_load(3'd0, 1'b0, 16'd10);
    run_ticks(5);
    check("R3 gate halt", 32'(count_o), 32'd10);
    gate = 1'b1;
    run_ticks(2);
    check("R3 gate resume", 32'(count_o), 32'd8);

    // R4: triggered one-shot
    gate = 1'b0;
    do_load(3'd1, 1'b0, 16'd5);
    check("R4 idle out", 32'(out_o), 32'd1);
    run_ticks(3);
    check("R4 no trigger hold", 32'(count_o), 32'd5);
    pulse_gate();
    run_ticks(1);
    check("R4 start count", 32'(count_o), 32'd5);
    check("R4 start out", 32'(out_o), 32'd0);
    run_ticks(4);
    check("R4 runs after gate low", 32'(count_o), 32'd1);
    check("R4 out low mid", 32'(out_o), 32'd0);
    run_ticks(1);
    check("R4 end count", 32'(count_o), 32'd0);
    check("R4 end out", 32'(out_o), 32'd1);
    check("R4 flag kept", 32'(loaded_o), 32'd1);

    // R10: hardware strobe
    do_load(3'd5, 1'b0, 16'd3);
    check("R10 idle out", 32'(out_o), 32'd1);
    pulse_gate();
    run_ticks(1);
    check("R10 start count", 32'(count_o), 32'd3);
    check("R10 start out", 32'(out_o), 32'd1);
    run_ticks(3);
    check("R10 end count", 32'(count_o), 32'd0);
    check("R10 pulse low", 32'(out_o), 32'd0);
    check("R10 flag clear", 32'(loaded_o), 32'd0);
    run_ticks(1);
    check("R10 pulse end", 32'(out_o), 32'd1);

    // R6: rate generator forced high by low gate
    gate = 1'b1;
    do_load(3'd2, 1'b0, 16'd5);
    run_ticks(4);
    check("R6 low before gate", 32'(out_o), 32'd0);
    @(negedge clk);
    gate = 1'b0;
    @(negedge clk);
    check("R6 forced high", 32'(out_o), 32'd1);
    run_ticks(3);
    check("R6 count halted", 32'(count_o), 32'd1);
    gate = 1'b1;
    run_ticks(1);
    check("R6 resume reload", 32'(count_o), 32'd5);

    finish_run();
  end

endmodule